// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. It divides a bit stream by a generator polynomial of degree N using a shift register with feedback, and it works in one of two modes chosen at the first bit of each frame.

In generate mode the message bits pass straight to the serial output, one cycle after they are taken in. After the last message bit the block stops taking input. It shifts N zero bits into its register and then sends the N-bit remainder out behind the message, highest coefficient first. In check mode the whole received frame, message followed by its check bits, is shifted through the same register. One cycle after the last bit a done pulse appears, together with an error flag that is set when the remainder is not zero.

The polynomial is a parameter: a tap mask of N bits with the leading x^N term implied. Input is a valid-qualified bit stream with start and last markers, and a ready output that drops during the tail of a generated frame.

Top module: `crc_serial_unit`

## Requirements
- R1: The generator is G(x) = x^N + sum of TAPS[i]·x^i. The first bit of a frame is the highest-degree coefficient. A beat with in_start_i clears the register before that beat's bit enters, and rem_o bit N-1 holds the highest remainder coefficient.
- R2: In generate mode (mode_check_i = 0 on the start beat) every accepted message bit appears on out_bit_o, with out_valid_o high, one cycle after the edge that accepts it, in arrival order.
- R3: After the last message bit of a generate frame, in_ready_o is low for exactly 2·N cycles: N zero-feed cycles followed by N emit cycles. It is high at every other time.
- R4: The check sequence equals (M·x^N) mod G. It is emitted MSB first after the zero-feed, and rem_o holds it unchanged until the next start beat. With N=3 and TAPS=3'b101, message 100101 gives the check sequence 100.
- R5: In check mode (mode_check_i = 1 on the start beat), done_o is high for one cycle after the edge that accepts the last bit. In that cycle rem_o equals the frame mod G and err_o is 1 exactly when rem_o is nonzero. With the defaults, frame 100101100 gives remainder 000 and err_o = 0.
- R6: err_o is 0 in every cycle in which done_o is 0, which includes the whole of every generate frame.
- R7: A beat with in_valid_i high that arrives outside a frame without in_start_i is ignored. It causes no out_valid_o, no done_o, and no change of rem_o.
- R8: A start beat inside an unfinished frame abandons that frame. The result depends only on the bits from the new start beat onward.
- R9: A one-bit frame (start and last on the same beat) in check mode gives a remainder equal to that bit, so a 1 sets err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_check_i | input | 1 | Frame mode, sampled on start beat: 0 generate, 1 check |
| in_valid_i | input | 1 | Input bit is valid |
| in_start_i | input | 1 | First bit of a frame |
| in_last_i | input | 1 | Last bit of a frame |
| in_bit_i | input | 1 | Serial input bit |
| in_ready_o | output | 1 | Block accepts an input beat this cycle |
| out_valid_o | output | 1 | out_bit_o carries a frame bit |
| out_bit_o | output | 1 | Serial output: message then check sequence |
| rem_o | output | N | Current remainder register |
| err_o | output | 1 | Nonzero remainder at end of a check frame |
| done_o | output | 1 | One-cycle pulse at end of a check frame |

## Verification
The hardest situation to reach from the ports is a new start beat landing in the middle of a frame, with a remainder already partly built up. A frame that is about to finish normally hides any failure to clear the register. The bench therefore first sends a run of random bits with no last marker, then starts a known-good frame and expects a zero remainder. It also drives valid beats with no start between frames, sends single-bit frames, and flips one bit of every generated frame, so that error detection is tested against remainders computed by long division in the bench.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_ZERO = 2'd1,
    ST_EMIT = 2'd2
  } crc_state_e;

  // One step of remainder update: r' = (r*x + b) mod G, for degree n <= 32.
  function automatic logic [31:0] crc_next(input logic [31:0] r,
                                           input logic        b,
                                           input logic [31:0] taps,
                                           input int unsigned n);
    logic        fb;
    logic [32:0] mask;
    logic [31:0] shifted;
    fb      = r[n-1];
    mask    = (33'd1 << n) - 33'd1;
    shifted = {r[30:0], b};
    return (shifted ^ (fb ? taps : 32'd0)) & mask[31:0];
  endfunction

endpackage

// File: rtl/crc_rem_reg.sv
module crc_rem_reg #(
  parameter int unsigned N    = 3,
  parameter logic [N-1:0] TAPS = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [N-1:0] rem_o,
  output logic [N-1:0] nxt_o
);
  import crc_serial_pkg::*;

  logic [N-1:0] rem_q;
  logic [N-1:0] base_w;

  assign base_w = clr_i ? '0 : rem_q;
  assign nxt_o  = N'(crc_next(32'(base_w), din_i, 32'(TAPS), N));
  assign rem_o  = rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rem_q <= '0;
    else if (shift_i) rem_q <= nxt_o;
    else if (clr_i)   rem_q <= '0;
  end
endmodule

// File: rtl/crc_seq.sv
module crc_seq #(
  parameter int unsigned N  = 3,
  localparam int unsigned CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_check_i,
  input  logic          in_valid_i,
  input  logic          in_start_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  output logic          take_o,
  output logic          clr_o,
  output logic          shift_o,
  output logic          check_o,
  output logic          last_take_o,
  output logic          feed_zero_o,
  output logic          emit_o,
  output logic [CW-1:0] cnt_o
);
  import crc_serial_pkg::*;

  crc_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          in_frame_q;
  logic          mode_q;
  logic          cnt_end_w;

  assign in_ready_o  = (state_q == ST_RUN);
  assign take_o      = in_valid_i & in_ready_o & (in_start_i | in_frame_q);
  assign check_o     = in_start_i ? mode_check_i : mode_q;
  assign clr_o       = take_o & in_start_i;
  assign feed_zero_o = (state_q == ST_ZERO);
  assign emit_o      = (state_q == ST_EMIT);
  assign shift_o     = take_o | feed_zero_o;
  assign last_take_o = take_o & in_last_i;
  assign cnt_o       = cnt_q;
  assign cnt_end_w   = (cnt_q == CW'(N-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      cnt_q      <= '0;
      in_frame_q <= 1'b0;
      mode_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: if (take_o) begin
          in_frame_q <= ~in_last_i;
          mode_q     <= check_o;
          if (in_last_i && !check_o) begin
            state_q <= ST_ZERO;
            cnt_q   <= '0;
          end
        end
        ST_ZERO: begin
          cnt_q <= cnt_end_w ? '0 : cnt_q + 1'b1;
          if (cnt_end_w) state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          cnt_q <= cnt_end_w ? '0 : cnt_q + 1'b1;
          if (cnt_end_w) state_q <= ST_RUN;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit #(
  parameter int unsigned  N    = 3,
  parameter logic [N-1:0] TAPS = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_check_i,
  input  logic         in_valid_i,
  input  logic         in_start_i,
  input  logic         in_last_i,
  input  logic         in_bit_i,
  output logic         in_ready_o,
  output logic         out_valid_o,
  output logic         out_bit_o,
  output logic [N-1:0] rem_o,
  output logic         err_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(N);

  // Named internal events, also used by the bound checker.
  logic          take_w;
  logic          clr_w;
  logic          shift_w;
  logic          check_w;
  logic          last_take_w;
  logic          feed_zero_w;
  logic          emit_w;
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] emit_pos_w;
  logic [N-1:0]  nxt_w;
  logic          din_w;

  logic out_valid_q, out_bit_q, err_q, done_q;

  crc_seq #(.N(N)) seq_i (
    .clk(clk), .rst_n(rst_n), .mode_check_i(mode_check_i),
    .in_valid_i(in_valid_i), .in_start_i(in_start_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .take_o(take_w), .clr_o(clr_w), .shift_o(shift_w),
    .check_o(check_w), .last_take_o(last_take_w), .feed_zero_o(feed_zero_w),
    .emit_o(emit_w), .cnt_o(cnt_w)
  );

  assign din_w = feed_zero_w ? 1'b0 : in_bit_i;

  crc_rem_reg #(.N(N), .TAPS(TAPS)) rem_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_w), .shift_i(shift_w),
    .din_i(din_w), .rem_o(rem_o), .nxt_o(nxt_w)
  );

  assign emit_pos_w = CW'(N-1) - cnt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_bit_q   <= 1'b0;
      err_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      out_valid_q <= (take_w & ~check_w) | emit_w;
      out_bit_q   <= emit_w ? rem_o[emit_pos_w] : in_bit_i;
      done_q      <= last_take_w & check_w;
      err_q       <= last_take_w & check_w & (nxt_w != '0);
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_bit_o   = out_bit_q;
  assign err_o       = err_q;
  assign done_o      = done_q;
endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
  parameter int unsigned N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_ready_o,
  input logic         done_o,
  input logic         err_o,
  input logic [N-1:0] rem_o,
  input logic         feed_zero_w,
  input logic         emit_w
);
  a_r3_no_input_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_zero_w || emit_w) |-> !in_ready_o);

  a_r3_zero_then_emit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(feed_zero_w) |-> emit_w);

  a_r4_rem_held_in_emit: assert property (@(posedge clk) disable iff (!rst_n)
    (emit_w && $past(emit_w)) |-> $stable(rem_o));

  a_r5_err_tracks_rem: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (err_o == (rem_o != '0)));

  a_r6_err_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
endmodule

bind crc_serial_unit crc_serial_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready_o(in_ready_o), .done_o(done_o),
  .err_o(err_o), .rem_o(rem_o), .feed_zero_w(feed_zero_w), .emit_w(emit_w)
);

// File: tb/crc_serial_unit_tb_top.sv
module crc_serial_unit_tb_top;
  localparam int N = 3;
  localparam logic [N-1:0] TAPS = 3'b101;
  typedef bit bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_check_i = 1'b0, in_valid_i = 1'b0, in_start_i = 1'b0;
  logic in_last_i = 1'b0, in_bit_i = 1'b0;
  logic in_ready_o, out_valid_o, out_bit_o, err_o, done_o;
  logic [N-1:0] rem_o;

  int checks = 0;
  int fails = 0;
  bit got[$];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  crc_serial_unit #(.N(N), .TAPS(TAPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_check_i(mode_check_i),
    .in_valid_i(in_valid_i), .in_start_i(in_start_i), .in_last_i(in_last_i),
    .in_bit_i(in_bit_i), .in_ready_o(in_ready_o), .out_valid_o(out_valid_o),
    .out_bit_o(out_bit_o), .rem_o(rem_o), .err_o(err_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Every-clock monitor: collect output stream, R6 flag discipline.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid_o) got.push_back(out_bit_o);
      chk(!(err_o && !done_o), "R6", $sformatf("err=%0b done=%0b exp err=0", err_o, done_o));
    end
  end

  // Reference: polynomial long division on a bit array, first bit highest degree.
  function automatic logic [N-1:0] ref_mod(input bq_t q);
    bit a[$];
    bit g[N+1];
    logic [N-1:0] r;
    a = q;
    g[0] = 1'b1;
    for (int j = 1; j <= N; j++) g[j] = TAPS[N-j];
    for (int i = 0; i + N < a.size(); i++)
      if (a[i]) for (int j = 0; j <= N; j++) a[i+j] = a[i+j] ^ g[j];
    r = '0;
    for (int j = 0; j < N; j++) begin
      int idx;
      idx = a.size() - N + j;
      if (idx >= 0) r[N-1-j] = a[idx];
    end
    return r;
  endfunction

  task automatic put(input bit b, input bit st, input bit ls, input bit md);
    while (!in_ready_o) @(negedge clk);
    in_valid_i = 1'b1; in_bit_i = b; in_start_i = st; in_last_i = ls;
    mode_check_i = md;
    @(negedge clk);
    in_valid_i = 1'b0; in_start_i = 1'b0; in_last_i = 1'b0;
  endtask

  task automatic gen_frame(input bq_t msg, output logic [N-1:0] cs);
    bit exp[$];
    bit aug[$];
    int stall;
    got.delete();
    for (int i = 0; i < msg.size(); i++) begin
      put(msg[i], i == 0, i == msg.size() - 1, 1'b0);
      if ($urandom_range(0, 3) == 0 && i != msg.size() - 1) @(negedge clk);
    end
    stall = 0;
    while (!in_ready_o) begin stall++; @(negedge clk); end
    @(negedge clk);
    chk(stall == 2 * N, "R3", $sformatf("stall=%0d exp=%0d", stall, 2 * N));
    aug = msg;
    for (int j = 0; j < N; j++) aug.push_back(1'b0);
    cs = ref_mod(aug);
    exp = msg;
    for (int j = N - 1; j >= 0; j--) exp.push_back(cs[j]);
    chk(got == exp, "R2", $sformatf("stream got %p exp %p", got, exp));
    chk(rem_o == cs, "R4", $sformatf("rem=%b exp=%b", rem_o, cs));
  endtask

  task automatic chk_frame(input bq_t fr, input string req);
    logic [N-1:0] r;
    r = ref_mod(fr);
    got.delete();
    for (int i = 0; i < fr.size(); i++) begin
      put(fr[i], i == 0, i == fr.size() - 1, 1'b1);
      if (i == fr.size() - 1) begin
        chk(done_o == 1'b1, req, $sformatf("done=%0b exp=1", done_o));
        chk(rem_o == r, req, $sformatf("rem=%b exp=%b", rem_o, r));
        chk(err_o == (r != '0), req, $sformatf("err=%0b exp=%0b", err_o, r != '0));
      end else if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R5", $sformatf("done pulse width: done=%0b exp=0", done_o));
    chk(got.size() == 0, "R5", $sformatf("check mode out beats=%0d exp=0", got.size()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    finished = 1'b1;
    $finish;
  end

  initial begin
    bit m[$];
    bit f[$];
    logic [N-1:0] cs;
    logic [N-1:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R1)
    chk(in_ready_o && !out_valid_o && !done_o && !err_o && rem_o == '0, "R1",
        $sformatf("reset rdy=%0b ov=%0b done=%0b err=%0b rem=%b exp 1 0 0 0 000",
                  in_ready_o, out_valid_o, done_o, err_o, rem_o));

    // Known vector: R4 literal
    m = '{1, 0, 0, 1, 0, 1};
    gen_frame(m, cs);
    chk(cs == 3'b100 && rem_o == 3'b100, "R4", $sformatf("cs=%b rem=%b exp=100", rem_o, rem_o));
    f = '{1, 0, 0, 1, 0, 1, 1, 0, 0};
    chk_frame(f, "R5");
    chk(rem_o == 3'b000 && !err_o, "R5", $sformatf("rem=%b exp=000", rem_o));

    // Ignored beats outside a frame (R7)
    hold = rem_o;
    got.delete();
    for (int i = 0; i < 4; i++) put(1'b1, 1'b0, i == 3, 1'b0);
    repeat (2) @(negedge clk);
    chk(got.size() == 0, "R7", $sformatf("out beats=%0d exp=0", got.size()));
    chk(rem_o == hold && !done_o, "R7", $sformatf("rem=%b exp=%b", rem_o, hold));

    // Restart mid-frame (R8)
    for (int i = 0; i < 5; i++) put(1'($urandom_range(0, 1)), i == 0, 1'b0, 1'b1);
    chk_frame(f, "R8");

    // Single-bit frames (R9)
    f = '{1};
    chk_frame(f, "R9");
    chk(rem_o == 3'b001 && err_o == 1'b0, "R9", $sformatf("rem=%b exp=001", rem_o));
    f = '{0};
    chk_frame(f, "R9");

    // Random frames: generate, check good copy, check corrupted copy (R1, R2, R4, R5)
    for (int t = 0; t < 20; t++) begin
      int len;
      int flip;
      m.delete();
      len = $urandom_range(4, 24);
      for (int i = 0; i < len; i++) m.push_back(1'($urandom_range(0, 1)));
      gen_frame(m, cs);
      f = m;
      for (int j = N - 1; j >= 0; j--) f.push_back(cs[j]);
      chk(ref_mod(f) == '0, "R1", "reference frame divisible");
      chk_frame(f, "R5");
      flip = $urandom_range(0, f.size() - 1);
      f[flip] = ~f[flip];
      chk(ref_mod(f) != '0, "R1", $sformatf("flipped bit %0d gives nonzero", flip));
      chk_frame(f, "R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    finished = 1'b1;
    $finish;
  end
endmodule